// File: doc/BRIEF.md
# Paired-Page Software-Managed Translation Buffer

The block is a fully associative address translation buffer that system software fills and inspects itself. Every entry describes one virtual page pair: an even page and an odd page that sit side by side in virtual space. The pair shares one tag and one page size, and each page has its own physical frame. The page size of each entry comes from its own page-mask word. Lookups run combinationally against the address on `va_i` under the address-space identifier held in the staged tag register. A lookup returns a hit flag, the physical address and a cacheable flag.

Software talks to the buffer through five staging registers: index, page mask, tag word, even-page word and odd-page word. It loads them through a simple write port. A command input then does one of four things: it probes for the staged tag, reads the indexed entry into the staging registers, writes the staging registers into the indexed entry, or writes them into an entry chosen by an externally supplied random index. Each command takes one clock. An entry that was just written serves lookups from the next cycle on.

The global attribute is held once per entry in the tag word. A write sets it only when both page words carry it. A read copies it back into both page words and removes it from the staged tag.

Top module: `paired_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and all five staging registers read zero.
- R2: An entry matches a lookup when the VPN2 bits of `va_i` equal the entry's tag VPN2 bits. Tag bits that the entry's page mask covers are ignored in this compare. The entry must also be global (tag bit 12) or have a tag ASID (bits 7:0) equal to bits 7:0 of the staged tag. With `mode64_i` = 1 the VPN2 bits are VA_W-1:13; with `mode64_i` = 0 they are bits 31:13, and higher address bits are ignored.
- R3: The page size is (mask + 0x2000) >> 1. The address bit equal to the page size picks the odd-page word when it is 1 and the even-page word when it is 0. The physical address is (PFN field bits 29:6 of that word, shifted left by 6) plus (va AND (page size − 1)), cut to PA_W bits.
- R4: `cacheable_o` is 1 unless the coherency field (bits 5:3) of the selected word equals 2.
- R5: Among matching entries the lowest-numbered one decides the lookup. If the page word it selects has its valid bit (bit 1) clear, the lookup misses, even when a later entry also matches.
- R6: Probe (command 1) sets index to 0xFFFFFFFF80000000 when nothing matches. Otherwise it writes the highest-numbered matching entry number. Probe compares the whole VPN2 without the page mask, and uses the same global/ASID rule as R2.
- R7: Write indexed (command 3) stores mask = staged mask AND 0x1FFE000. It stores the tag as staged tag with the stored mask bits and bit 12 cleared, then sets bit 12 only if bit 0 is set in both staged page words. Both stored page words get bit 0 cleared. Lookups see the new entry in the next cycle.
- R8: Write random (command 4) performs the R7 store into the entry given by `rand_idx_i`.
- R9: Read (command 2) copies the indexed entry's mask, tag and page words into the staging registers. For a global entry, bit 0 is set in both staged page words and bit 12 is cleared in the staged tag.
- R10: A read or an indexed write whose index is not less than N_ENTRIES changes neither the staging registers nor the table.
- R11: `stg_we_i` loads `stg_wdata_i` into the register chosen by `stg_sel_i` (0 index, 1 mask, 2 tag, 3 even word, 4 odd word). A command in the same cycle overrides the staging registers it updates. Command code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| va_i | input | 64 | Lookup virtual address |
| mode64_i | input | 1 | 1 selects wide addressing for VPN2 compare |
| hit_o | output | 1 | Lookup hit |
| pa_o | output | PA_W | Translated physical address |
| cacheable_o | output | 1 | Selected page is cacheable |
| cmd_i | input | 3 | Maintenance command code |
| rand_idx_i | input | IDX_W | Target entry for write random |
| stg_we_i | input | 1 | Staging register write enable |
| stg_sel_i | input | 3 | Staging register select |
| stg_wdata_i | input | 64 | Staging register write data |
| index_o | output | 64 | Staged index |
| pagemask_o | output | 64 | Staged page mask |
| entryhi_o | output | 64 | Staged tag word |
| entrylo0_o | output | 64 | Staged even-page word |
| entrylo1_o | output | 64 | Staged odd-page word |

## Verification
A corrupted table entry shows up on the lookup outputs as soon as `va_i` points into that page pair, because translation is combinational. It also shows up one cycle after a read, in the staged words. A wrong priority picker shows up in two places: an overlapping lookup returns the later entry's frame, and a probe returns the lower entry number. A fault in the global-bit fold only shows after a write followed by a read, or in a lookup under a foreign ASID. For that reason the sweeps repeat every address under two ASIDs and both addressing modes.

// File: rtl/paired_tlb_pkg.sv
package paired_tlb_pkg;
  localparam int HI_G_BIT = 12;
  localparam int LO_G_BIT = 0;
  localparam int LO_V_BIT = 1;
  localparam logic [63:0] MASK_FIELD = 64'h0000_0000_01FF_E000;
  localparam logic [63:0] FAIL_IDX   = 64'hFFFF_FFFF_8000_0000;

  typedef struct packed {
    logic [63:0] mask;
    logic [63:0] hi;
    logic [63:0] lo0;
    logic [63:0] lo1;
  } tlb_ent_t;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_PROBE     = 3'd1,
    CMD_READ      = 3'd2,
    CMD_WRITE_IDX = 3'd3,
    CMD_WRITE_RND = 3'd4
  } tlb_cmd_e;

  typedef enum logic [2:0] {
    STG_INDEX = 3'd0,
    STG_MASK  = 3'd1,
    STG_HI    = 3'd2,
    STG_LO0   = 3'd3,
    STG_LO1   = 3'd4
  } stg_sel_e;
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import paired_tlb_pkg::*;
(
  input  tlb_ent_t    ent_i,
  input  logic [63:0] va_i,
  input  logic [63:0] vm_i,
  input  logic [63:0] probe_hi_i,
  input  logic [7:0]  asid_i,
  output logic        lk_match_o,
  output logic        pr_match_o,
  output logic [63:0] lo_o,
  output logic [63:0] psz_o
);
  logic        asid_ok;
  logic [63:0] cmp_mask;
  logic [63:0] tag;

  assign asid_ok  = ent_i.hi[HI_G_BIT] || (ent_i.hi[7:0] == asid_i);
  assign cmp_mask = ~(ent_i.mask + 64'h1FFF);
  assign tag      = ent_i.hi & vm_i;

  assign lk_match_o = ((va_i & vm_i & cmp_mask) == tag) && asid_ok;
  // probe ignores the page mask: exact VPN2
  assign pr_match_o = ((probe_hi_i & vm_i) == tag) && asid_ok;

  assign psz_o = (ent_i.mask + 64'h2000) >> 1;
  assign lo_o  = |(va_i & psz_o) ? ent_i.lo1 : ent_i.lo0;
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int N       = 8,
  parameter int IDX_W   = 3,
  parameter bit HIGHEST = 1'b0
) (
  input  logic [N-1:0]     hit_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  assign found_o = |hit_i;

  generate
    if (HIGHEST) begin : g_high
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++)
          if (hit_i[i]) idx_o = IDX_W'(i);
      end
    end else begin : g_low
      always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--)
          if (hit_i[i]) idx_o = IDX_W'(i);
      end
    end
  endgenerate
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int PA_W = 36
) (
  input  logic [63:0]     lo_i,
  input  logic [63:0]     psz_i,
  input  logic [63:0]     va_i,
  output logic            valid_o,
  output logic [PA_W-1:0] pa_o,
  output logic            cacheable_o
);
  localparam logic [63:0] PFN_MASK = ((64'd1 << (PA_W - 6)) - 64'd1) & ~64'h3F;
  localparam logic [63:0] COH_MASK = 64'h38;
  localparam logic [63:0] COH_UNC  = 64'h10;

  assign valid_o     = lo_i[1];
  assign pa_o        = PA_W'(((lo_i & PFN_MASK) << 6) + (va_i & (psz_i - 64'd1)));
  assign cacheable_o = (lo_i & COH_MASK) != COH_UNC;
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
  import paired_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VA_W      = 40,
  parameter int PA_W      = 36,
  parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [63:0]      va_i,
  input  logic             mode64_i,
  output logic             hit_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             cacheable_o,
  input  logic [2:0]       cmd_i,
  input  logic [IDX_W-1:0] rand_idx_i,
  input  logic             stg_we_i,
  input  logic [2:0]       stg_sel_i,
  input  logic [63:0]      stg_wdata_i,
  output logic [63:0]      index_o,
  output logic [63:0]      pagemask_o,
  output logic [63:0]      entryhi_o,
  output logic [63:0]      entrylo0_o,
  output logic [63:0]      entrylo1_o
);
  localparam logic [63:0] VM64  = ((64'd1 << VA_W) - 64'd1) & ~64'h1FFF;
  localparam logic [63:0] VM32  = 64'h0000_0000_FFFF_E000;
  localparam logic [63:0] N_LIM = 64'(N_ENTRIES);
  localparam logic [63:0] G_HI  = 64'd1 << HI_G_BIT;
  localparam logic [63:0] G_LO  = 64'd1 << LO_G_BIT;

  tlb_cmd_e cmd_e;
  stg_sel_e sel_e;
  assign cmd_e = tlb_cmd_e'(cmd_i);
  assign sel_e = stg_sel_e'(stg_sel_i);

  tlb_ent_t [N_ENTRIES-1:0] tbl_q;
  logic [63:0] idx_q, pm_q, hi_q, lo0_q, lo1_q;

  logic [63:0] vm;
  assign vm = mode64_i ? VM64 : VM32;

  // per-entry compare
  logic [N_ENTRIES-1:0] lk_match, pr_match;
  logic [63:0]          ent_lo  [N_ENTRIES];
  logic [63:0]          ent_psz [N_ENTRIES];

  generate
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      tlb_entry_cmp u_cmp (
        .ent_i      (tbl_q[g]),
        .va_i       (va_i),
        .vm_i       (vm),
        .probe_hi_i (hi_q),
        .asid_i     (hi_q[7:0]),
        .lk_match_o (lk_match[g]),
        .pr_match_o (pr_match[g]),
        .lo_o       (ent_lo[g]),
        .psz_o      (ent_psz[g])
      );
    end
  endgenerate

  logic             lk_found, pr_found;
  logic [IDX_W-1:0] lk_idx, pr_idx;

  tlb_pick #(.N(N_ENTRIES), .IDX_W(IDX_W), .HIGHEST(1'b0)) u_pick_lk (
    .hit_i(lk_match), .found_o(lk_found), .idx_o(lk_idx)
  );
  tlb_pick #(.N(N_ENTRIES), .IDX_W(IDX_W), .HIGHEST(1'b1)) u_pick_pr (
    .hit_i(pr_match), .found_o(pr_found), .idx_o(pr_idx)
  );

  logic sel_valid;
  tlb_xlate #(.PA_W(PA_W)) u_xlate (
    .lo_i        (ent_lo[lk_idx]),
    .psz_i       (ent_psz[lk_idx]),
    .va_i        (va_i),
    .valid_o     (sel_valid),
    .pa_o        (pa_o),
    .cacheable_o (cacheable_o)
  );
  // first match decides; its invalid half is a miss
  assign hit_o = lk_found && sel_valid;

  // command datapath
  logic             idx_ok, rnd_ok;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;
  tlb_ent_t         wr_ent, rd_ent;

  assign idx_ok = idx_q < N_LIM;
  assign rnd_ok = 64'(rand_idx_i) < N_LIM;
  assign wr_idx = (cmd_e == CMD_WRITE_RND) ? rand_idx_i : idx_q[IDX_W-1:0];
  assign wr_en  = ((cmd_e == CMD_WRITE_IDX) && idx_ok) ||
                  ((cmd_e == CMD_WRITE_RND) && rnd_ok);

  always_comb begin
    wr_ent.mask = pm_q & MASK_FIELD;
    wr_ent.hi   = hi_q & ~wr_ent.mask & ~G_HI;
    if (lo0_q[LO_G_BIT] && lo1_q[LO_G_BIT]) wr_ent.hi = wr_ent.hi | G_HI;
    wr_ent.lo0  = lo0_q & ~G_LO;
    wr_ent.lo1  = lo1_q & ~G_LO;
  end

  always_comb begin
    rd_ent = tbl_q[idx_q[IDX_W-1:0]];
    if (rd_ent.hi[HI_G_BIT]) begin
      rd_ent.lo0 = rd_ent.lo0 | G_LO;
      rd_ent.lo1 = rd_ent.lo1 | G_LO;
      rd_ent.hi  = rd_ent.hi & ~G_HI;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_ent;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      pm_q  <= '0;
      hi_q  <= '0;
      lo0_q <= '0;
      lo1_q <= '0;
    end else begin
      if (stg_we_i) begin
        case (sel_e)
          STG_INDEX: idx_q <= stg_wdata_i;
          STG_MASK:  pm_q  <= stg_wdata_i;
          STG_HI:    hi_q  <= stg_wdata_i;
          STG_LO0:   lo0_q <= stg_wdata_i;
          STG_LO1:   lo1_q <= stg_wdata_i;
          default:   ;
        endcase
      end
      // command has priority over the staging write port
      case (cmd_e)
        CMD_PROBE: idx_q <= pr_found ? 64'(pr_idx) : FAIL_IDX;
        CMD_READ: if (idx_ok) begin
          pm_q  <= rd_ent.mask;
          hi_q  <= rd_ent.hi;
          lo0_q <= rd_ent.lo0;
          lo1_q <= rd_ent.lo1;
        end
        default: ;
      endcase
    end
  end

  assign index_o    = idx_q;
  assign pagemask_o = pm_q;
  assign entryhi_o  = hi_q;
  assign entrylo0_o = lo0_q;
  assign entrylo1_o = lo1_q;

  AST_PROBE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_e == CMD_PROBE) |=> (idx_q == FAIL_IDX || idx_q < N_LIM)); // R6
  AST_READ_HI_NO_G: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_e == CMD_READ && idx_ok) |=> !hi_q[HI_G_BIT]); // R9
  AST_READ_GLOBAL_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_e == CMD_READ && idx_ok && tbl_q[idx_q[IDX_W-1:0]].hi[HI_G_BIT])
    |=> (lo0_q[LO_G_BIT] && lo1_q[LO_G_BIT])); // R9
  AST_OOR_WRITE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_e == CMD_WRITE_IDX && !idx_ok) |=> $stable(tbl_q)); // R10
  AST_PA_PAGE_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (pa_o[11:0] == va_i[11:0])); // R3
  AST_HIT_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (lk_match != '0)); // R2
endmodule

// File: tb/paired_tlb_test.sv
`timescale 1ns/1ps
module paired_tlb_test;
  localparam int N     = 8;
  localparam int VA_W  = 40;
  localparam int PA_W  = 36;
  localparam int IDX_W = 3;
  localparam logic [63:0] FAIL_V = 64'hFFFF_FFFF_8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] va_i = '0;
  logic        mode64_i = 1'b1;
  logic        hit_o, cacheable_o;
  logic [PA_W-1:0] pa_o;
  logic [2:0]  cmd_i = '0;
  logic [IDX_W-1:0] rand_idx_i = '0;
  logic        stg_we_i = 1'b0;
  logic [2:0]  stg_sel_i = '0;
  logic [63:0] stg_wdata_i = '0;
  logic [63:0] index_o, pagemask_o, entryhi_o, entrylo0_o, entrylo1_o;

  paired_tlb #(.N_ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .va_i(va_i), .mode64_i(mode64_i),
    .hit_o(hit_o), .pa_o(pa_o), .cacheable_o(cacheable_o),
    .cmd_i(cmd_i), .rand_idx_i(rand_idx_i), .stg_we_i(stg_we_i),
    .stg_sel_i(stg_sel_i), .stg_wdata_i(stg_wdata_i),
    .index_o(index_o), .pagemask_o(pagemask_o), .entryhi_o(entryhi_o),
    .entrylo0_o(entrylo0_o), .entrylo1_o(entrylo1_o)
  );

  int checks = 0;
  int fails  = 0;
  logic [63:0] m_mask [N];
  logic [63:0] m_hi   [N];
  logic [63:0] m_lo0  [N];
  logic [63:0] m_lo1  [N];
  logic [63:0] s_idx = 0, s_pm = 0, s_hi = 0, s_lo0 = 0, s_lo1 = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] vmask();
    return mode64_i ? (((64'd1 << VA_W) - 1) & ~64'h1FFF) : 64'hFFFF_E000;
  endfunction

  function automatic logic [63:0] lo_word(input int pfn, input int coh, input bit v, input bit g);
    return (64'(pfn) << 6) | (64'(coh) << 3) | (64'(v) << 1) | 64'(g);
  endfunction

  task automatic model_lookup(input logic [63:0] va, output bit hit,
                              output logic [63:0] pa, output bit cach);
    hit = 0; pa = 0; cach = 0;
    for (int i = 0; i < N; i++) begin
      logic [63:0] ps, lo;
      if (((va & vmask() & ~(m_mask[i] + 64'h1FFF)) == (m_hi[i] & vmask())) &&
          (m_hi[i][12] || m_hi[i][7:0] == s_hi[7:0])) begin
        ps = (m_mask[i] + 64'h2000) >> 1;
        lo = ((va & ps) != 0) ? m_lo1[i] : m_lo0[i];
        if (lo[1]) begin
          hit  = 1;
          pa   = ((((lo >> 6) & ((64'd1 << (PA_W - 12)) - 1)) << 12) + (va & (ps - 1)))
                 & ((64'd1 << PA_W) - 1);
          cach = (lo[5:3] != 3'd2);
        end
        return;
      end
    end
  endtask

  task automatic look(input logic [63:0] va);
    bit h, c;
    logic [63:0] p;
    va_i = va;
    #1;
    model_lookup(va, h, p, c);
    chk("R2/R5 hit", 64'(hit_o), 64'(h));
    if (h) begin
      chk("R3 pa", 64'(pa_o), p);
      chk("R4 cacheable", 64'(cacheable_o), 64'(c));
    end
  endtask

  task automatic model_stg(input int sel, input logic [63:0] v);
    case (sel)
      0: s_idx = v;
      1: s_pm  = v;
      2: s_hi  = v;
      3: s_lo0 = v;
      4: s_lo1 = v;
      default: ;
    endcase
  endtask

  task automatic model_cmd(input int c);
    logic [63:0] t, mk;
    case (c)
      1: begin
        s_idx = FAIL_V;
        for (int i = 0; i < N; i++)
          if (((m_hi[i] & vmask()) == (s_hi & vmask())) &&
              (m_hi[i][12] || m_hi[i][7:0] == s_hi[7:0])) s_idx = 64'(i);
      end
      2: if (s_idx < N) begin
        s_pm = m_mask[s_idx]; s_hi = m_hi[s_idx];
        s_lo0 = m_lo0[s_idx]; s_lo1 = m_lo1[s_idx];
        if (s_hi[12]) begin
          s_lo0 = s_lo0 | 64'd1; s_lo1 = s_lo1 | 64'd1; s_hi = s_hi & ~64'h1000;
        end
      end
      3, 4: begin
        t = (c == 3) ? s_idx : 64'(rand_idx_i);
        if (t < N) begin
          mk = s_pm & 64'h1FF_E000;
          m_mask[t] = mk;
          m_hi[t]   = (s_hi & ~mk & ~64'h1000) | ((s_lo0[0] && s_lo1[0]) ? 64'h1000 : 64'h0);
          m_lo0[t]  = s_lo0 & ~64'd1;
          m_lo1[t]  = s_lo1 & ~64'd1;
        end
      end
      default: ;
    endcase
  endtask

  task automatic step(input bit we, input int sel, input logic [63:0] v, input int c);
    @(negedge clk);
    stg_we_i = we; stg_sel_i = 3'(sel); stg_wdata_i = v; cmd_i = 3'(c);
    @(posedge clk);
    #1;
    stg_we_i = 0; cmd_i = 0;
    if (we) model_stg(sel, v);
    model_cmd(c);
  endtask

  task automatic stg(input int sel, input logic [63:0] v); step(1, sel, v, 0); endtask
  task automatic cmd(input int c); step(0, 0, 0, c); endtask

  task automatic check_staging(input string req);
    chk({req, " index"}, index_o, s_idx);
    chk({req, " mask"}, pagemask_o, s_pm);
    chk({req, " hi"}, entryhi_o, s_hi);
    chk({req, " lo0"}, entrylo0_o, s_lo0);
    chk({req, " lo1"}, entrylo1_o, s_lo1);
  endtask

  task automatic put(input int idx, input logic [63:0] pm, input logic [63:0] hi,
                     input logic [63:0] l0, input logic [63:0] l1, input bit rnd);
    stg(1, pm); stg(2, hi); stg(3, l0); stg(4, l1);
    if (rnd) begin rand_idx_i = 3'(idx); cmd(4); end
    else begin stg(0, 64'(idx)); cmd(3); end
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] bases [8];
    logic [63:0] offs  [7];
    logic [63:0] keep;
    for (int i = 0; i < N; i++) begin m_mask[i] = 0; m_hi[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0; end
    bases = '{64'h4000, 64'h10_0000, 64'h80_0000, 64'h10_0200_0000,
              64'h200_0000, 64'h300_0000, 64'hFF00_0000_4000, 64'h0};
    offs  = '{64'h0, 64'hFFC, 64'h1000, 64'h2000, 64'h3FFC, 64'h6000, 64'h1_0000};
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_staging("R1 reset");
    va_i = 64'h4000; #1;
    chk("R1 reset miss", 64'(hit_o), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // table fill
    put(0, 0, 64'h4000 | 5, lo_word('h100, 3, 1, 0), lo_word('h200, 2, 1, 0), 0);
    stg(2, 64'h5);
    look(64'h4000);           // R7: new entry visible next cycle
    look(64'h6010);
    put(1, 64'h6000, 64'h10_0000 | 9, lo_word('h300, 3, 1, 1), lo_word('h400, 3, 0, 1), 0);
    put(7, 64'h6000, 64'h10_0000 | 5, lo_word('h500, 3, 1, 1), lo_word('h500, 3, 1, 1), 0);
    put(2, 0, 64'h4000 | 6, lo_word('h600, 3, 1, 0), lo_word('h601, 5, 1, 0), 0);
    put(3, 64'h1E000, 64'h80_6000 | 5, lo_word('h700, 3, 1, 1), lo_word('h740, 0, 1, 0), 0);
    put(5, 0, 64'h10_0200_0000 | 5, lo_word('h800, 3, 1, 0), 64'h0, 1);  // R8
    put(6, 0, 64'h4000 | 5, lo_word('h900, 3, 1, 0), lo_word('h901, 3, 1, 0), 0);
    // R10: out of range indexed write
    put(9, 0, 64'h300_0000 | 5, lo_word('hA00, 3, 1, 0), lo_word('hA01, 3, 1, 0), 0);

    // R2..R5 sweep over modes, ASIDs, pages and offsets
    for (int m = 0; m < 2; m++) begin
      mode64_i = m[0];
      for (int a = 5; a <= 6; a++) begin
        stg(2, 64'(a));
        for (int b = 0; b < 8; b++)
          for (int o = 0; o < 7; o++) look(bases[b] + offs[o]);
      end
    end
    mode64_i = 1'b1;
    stg(2, 64'h5);
    va_i = 64'h300_0000; #1;
    chk("R10 oor write no entry", 64'(hit_o), 64'd0);
    va_i = 64'h4000; #1;
    chk("R5 lowest entry frame", 64'(pa_o), 64'h10_0000);
    va_i = 64'h10_6000; #1;
    chk("R5 invalid half stops search", 64'(hit_o), 64'd0);

    // R6 probe
    stg(2, 64'h4000 | 5); cmd(1);
    chk("R6 probe highest", index_o, 64'd6);
    stg(2, 64'h10_0000 | 3); cmd(1);
    chk("R6 probe global", index_o, 64'd7);
    stg(2, 64'h80_0000 | 5); cmd(1);
    chk("R6 probe masked entry", index_o, 64'd3);
    stg(2, 64'h80_4000 | 5); cmd(1);
    chk("R6 probe no page mask", index_o, FAIL_V);
    stg(2, 64'h300_0000 | 5); cmd(1);
    chk("R6 probe fail", index_o, FAIL_V);

    // R9 read back, R7 fold checks
    for (int i = 0; i < N; i++) begin
      stg(0, 64'(i)); cmd(2);
      check_staging("R9 read");
    end
    stg(0, 64'd1); cmd(2);
    chk("R9 global lo0 G", 64'(entrylo0_o[0]), 64'd1);
    chk("R9 global hi G", 64'(entryhi_o[12]), 64'd0);
    stg(0, 64'd3); cmd(2);
    chk("R7 masked hi", entryhi_o, 64'h80_0000 | 5);
    chk("R7 lo G cleared", 64'(entrylo0_o[0]), 64'd0);

    // R10 out of range read
    stg(0, 64'd12);
    keep = entryhi_o;
    cmd(2);
    check_staging("R10 oor read");
    chk("R10 oor read hi", entryhi_o, keep);

    // R11 command overrides same-cycle staging write
    stg(2, 64'h4000 | 5);
    step(1, 0, 64'd2, 1);
    chk("R11 probe over stg write", index_o, 64'd6);
    step(1, 3, 64'h1234_5678, 0);
    chk("R11 stg write lo0", entrylo0_o, 64'h1234_5678);
    step(1, 5, 64'hDEAD, 0);
    check_staging("R11 bad select");
    step(0, 0, 0, 7);
    check_staging("R11 bad command");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule